// File: doc/BRIEF.md
# Paired-Accumulator Arithmetic Unit

This unit holds the two 8-bit accumulators of a small 8-bit processor and also runs a set of 16-bit operations on them as one word. The word is not a third register. It is the high accumulator placed above the low accumulator. Loading a 16-bit value splits it across the pair, and reading the word joins the pair back together. A single command multiplies the two accumulators and places the product back into the pair.

A sequencer selects an operation with a 3-bit code, puts the operand on a 16-bit bus and raises `start` for one cycle. The unit answers with a one-cycle `done` pulse. At that point the word, the N/Z/V/C condition flags and, for a store, the outgoing data are all valid. Every operation except multiply finishes at the edge that accepts the command. Multiply uses one shift-and-add step for each multiplier bit and keeps `busy` high while it runs. There is no divide and no separate 16-bit compare; a subtract does the compare.

Top module: `pa_accum_unit`

## Requirements
- R1: After reset, both accumulators are zero, all four flags are zero, and `done` and `busy` are low. `d_out[15:8]` always shows accumulator A and `d_out[7:0]` shows accumulator B.
- R2: Opcode 0 (load) writes `opnd` into the pair, so loading 0xABCD gives A=0xAB and B=0xCD. N is set to bit 15 and Z to (value==0). V is cleared and C is left unchanged. `done` is high in the cycle after the accepting edge.
- R3: Opcode 1 (store) drives the current word on `store_data` and leaves the pair unchanged. It sets N and Z from the word, clears V and keeps C.
- R4: Opcode 2 (add) writes the 16-bit sum of the word and `opnd`. C is the carry out of bit 15 and V is the signed two's-complement overflow. N and Z come from the result.
- R5: Opcode 3 (subtract) writes the word minus `opnd`. C is set when a borrow comes out of bit 15 (unsigned word < operand) and V is the signed overflow. N and Z come from the result.
- R6: Opcode 4 (multiply) replaces the pair with the unsigned product A×B. C is set to bit 7 of the product and N, Z and V are left unchanged. `done` appears 8 cycles after the accepting edge, `busy` is high until then, and the pair does not change before `done`.
- R7: Opcode 5 (shift left) shifts the word left by one and fills bit 0 with 0. C takes the old bit 15 and V = N xor C.
- R8: Opcode 6 (shift right) shifts the word right by one and fills bit 15 with 0. C takes the old bit 0, N is cleared and V = N xor C.
- R9: A `start` that arrives while `busy` is high is ignored: it changes neither the pair nor the flags, and it produces no `done`.
- R10: Opcode 7 is reserved. It gives a `done` pulse one cycle after the accepting edge and leaves the pair, the flags and `store_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, accepted when not busy |
| op | input | 3 | Operation code (0 load … 7 reserved) |
| opnd | input | 16 | 16-bit operand |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Multiply in progress |
| d_out | output | 16 | Accumulator pair, A high, B low |
| store_data | output | 16 | Data from the last store |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry/borrow flag |

## Verification
The word, the flags and `store_data` are all registered ports. A corrupted accumulator or flag therefore shows at the ports in the cycle after the edge that caused it, and it carries into later add, shift and multiply results. A fault in the multiply step counter or partial product shows as a wrong product or a `done` that comes early or late; the bench checks the latency of every command. A fault in the busy guard shows as an extra `done` or a changed word after a command that should have been ignored.

// File: rtl/pa_pkg.sv
package pa_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_ADD   = 3'd2,
        OP_SUB   = 3'd3,
        OP_MUL   = 3'd4,
        OP_SHL   = 3'd5,
        OP_SHR   = 3'd6,
        OP_RSVD  = 3'd7
    } pa_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } pa_flags_t;

    // N/Z from a word, V cleared, C kept from the previous flags
    function automatic pa_flags_t flags_nz(input logic [WORD_W-1:0] w, input logic c_keep);
        pa_flags_t f;
        f.n = w[WORD_W-1];
        f.z = (w == '0);
        f.v = 1'b0;
        f.c = c_keep;
        return f;
    endfunction

endpackage

// File: rtl/pa_addsub.sv
module pa_addsub
    import pa_pkg::*;
#(
    parameter int WW = pa_pkg::WORD_W
) (
    input  logic [WW-1:0] x,
    input  logic [WW-1:0] y,
    input  logic          sub,
    output logic [WW-1:0] res,
    output pa_flags_t     fl
);
    localparam int MSB = WW - 1;

    logic [WW:0] ext;

    always_comb begin
        if (sub) ext = {1'b0, x} - {1'b0, y};
        else     ext = {1'b0, x} + {1'b0, y};
        res  = ext[WW-1:0];
        fl.c = ext[WW];
        fl.n = res[MSB];
        fl.z = (res == '0);
        if (sub) fl.v = (x[MSB] != y[MSB]) && (res[MSB] != x[MSB]);
        else     fl.v = (x[MSB] == y[MSB]) && (res[MSB] != x[MSB]);
    end

endmodule

// File: rtl/pa_shift.sv
module pa_shift
    import pa_pkg::*;
#(
    parameter int WW = pa_pkg::WORD_W
) (
    input  logic [WW-1:0] x,
    input  logic          left,
    output logic [WW-1:0] res,
    output pa_flags_t     fl
);
    always_comb begin
        if (left) begin
            res  = {x[WW-2:0], 1'b0};
            fl.c = x[WW-1];
        end else begin
            res  = {1'b0, x[WW-1:1]};
            fl.c = x[0];
        end
        fl.n = res[WW-1];
        fl.z = (res == '0);
        fl.v = fl.n ^ fl.c;
    end

endmodule

// File: rtl/pa_mul.sv
module pa_mul #(
    parameter int BW = pa_pkg::BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [BW-1:0] a,
    input  logic [BW-1:0] b,
    output logic          busy,
    output logic          last,
    output logic [2*BW-1:0] prod_next
);
    localparam int WW = 2 * BW;
    localparam int CW = (BW > 1) ? $clog2(BW) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(BW - 1);

    logic [WW-1:0] acc;
    logic [WW-1:0] mcand;
    logic [BW-1:0] mplr;
    logic [CW-1:0] cnt;

    assign last      = busy && (cnt == LAST_STEP);
    assign prod_next = acc + (mplr[0] ? mcand : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            acc   <= '0;
            mcand <= '0;
            mplr  <= '0;
            cnt   <= '0;
        end else if (go && !busy) begin
            busy  <= 1'b1;
            acc   <= '0;
            mcand <= {{BW{1'b0}}, a};
            mplr  <= b;
            cnt   <= '0;
        end else if (busy) begin
            acc   <= prod_next;
            mcand <= mcand << 1;
            mplr  <= mplr >> 1;
            cnt   <= cnt + 1'b1;
            if (last) busy <= 1'b0;
        end
    end

    // R6: the engine goes idle right after its final step
    a_r6_idle_after_last: assert property (@(posedge clk) disable iff (rst)
        last |=> !busy);

    // R6: a new multiply cannot restart the step counter mid-run
    a_r6_count_advances: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> (busy && cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/pa_accum_unit.sv
module pa_accum_unit
    import pa_pkg::*;
#(
    parameter int BW = pa_pkg::BYTE_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [2:0]      op,
    input  logic [2*BW-1:0] opnd,
    output logic            done,
    output logic            busy,
    output logic [2*BW-1:0] d_out,
    output logic [2*BW-1:0] store_data,
    output logic            flag_n,
    output logic            flag_z,
    output logic            flag_v,
    output logic            flag_c
);
    localparam int WW = 2 * BW;

    logic [BW-1:0] acc_a, acc_b;
    pa_flags_t     fl_q;
    logic          done_q;
    logic [WW-1:0] st_q;

    logic          go;
    pa_op_e        opc;
    logic [WW-1:0] word;

    logic [WW-1:0] as_res, sh_res, mul_prod;
    pa_flags_t     as_fl, sh_fl;
    logic          mul_busy, mul_last;

    assign opc  = pa_op_e'(op);
    assign word = {acc_a, acc_b};
    assign go   = start && !mul_busy;

    pa_addsub #(.WW(WW)) u_addsub (
        .x   (word),
        .y   (opnd),
        .sub (opc == OP_SUB),
        .res (as_res),
        .fl  (as_fl)
    );

    pa_shift #(.WW(WW)) u_shift (
        .x    (word),
        .left (opc == OP_SHL),
        .res  (sh_res),
        .fl   (sh_fl)
    );

    pa_mul #(.BW(BW)) u_mul (
        .clk       (clk),
        .rst       (rst),
        .go        (go && opc == OP_MUL),
        .a         (acc_a),
        .b         (acc_b),
        .busy      (mul_busy),
        .last      (mul_last),
        .prod_next (mul_prod)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_a  <= '0;
            acc_b  <= '0;
            fl_q   <= '0;
            done_q <= 1'b0;
            st_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (go) begin
                unique case (opc)
                    OP_LOAD: begin
                        {acc_a, acc_b} <= opnd;
                        fl_q   <= flags_nz(opnd, fl_q.c);
                        done_q <= 1'b1;
                    end
                    OP_STORE: begin
                        st_q   <= word;
                        fl_q   <= flags_nz(word, fl_q.c);
                        done_q <= 1'b1;
                    end
                    OP_ADD, OP_SUB: begin
                        {acc_a, acc_b} <= as_res;
                        fl_q   <= as_fl;
                        done_q <= 1'b1;
                    end
                    OP_SHL, OP_SHR: begin
                        {acc_a, acc_b} <= sh_res;
                        fl_q   <= sh_fl;
                        done_q <= 1'b1;
                    end
                    OP_MUL: begin
                    end
                    OP_RSVD: begin
                        done_q <= 1'b1;
                    end
                    default: begin
                    end
                endcase
            end
            if (mul_last) begin
                {acc_a, acc_b} <= mul_prod;
                fl_q.c <= mul_prod[BW-1];
                done_q <= 1'b1;
            end
        end
    end

    assign done       = done_q;
    assign busy       = mul_busy;
    assign d_out      = word;
    assign store_data = st_q;
    assign flag_n     = fl_q.n;
    assign flag_z     = fl_q.z;
    assign flag_v     = fl_q.v;
    assign flag_c     = fl_q.c;

    // R2: a load lands on the pair with V cleared and done raised
    a_r2_load_lands: assert property (@(posedge clk) disable iff (rst)
        (go && opc == OP_LOAD) |=> (d_out == $past(opnd) && !flag_v && done));

    // R3: store leaves the pair alone and exposes it
    a_r3_store_copy: assert property (@(posedge clk) disable iff (rst)
        (go && opc == OP_STORE) |=> (store_data == $past(d_out) && $stable(d_out)));

    // R6: no completion while the multiplier is still running
    a_r6_no_early_done: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    // R8: right shift always clears N
    a_r8_shr_clears_n: assert property (@(posedge clk) disable iff (rst)
        (go && opc == OP_SHR) |=> !flag_n);

    // R9: the pair holds while the multiplier runs
    a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> $stable(d_out));

    // R10: reserved code completes with nothing changed
    a_r10_rsvd_inert: assert property (@(posedge clk) disable iff (rst)
        (go && opc == OP_RSVD) |=> (done && $stable(d_out) && $stable(store_data)
                                    && $stable({flag_n, flag_z, flag_v, flag_c})));

endmodule

// File: tb/tb_pa_accum_unit.sv
module tb_pa_accum_unit;

    localparam int BW = 8;
    localparam int WW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [2:0]    op = 3'd0;
    logic [WW-1:0] opnd = '0;
    logic          done, busy;
    logic [WW-1:0] d_out, store_data;
    logic          flag_n, flag_z, flag_v, flag_c;

    pa_accum_unit #(.BW(BW)) dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .opnd(opnd),
        .done(done), .busy(busy), .d_out(d_out), .store_data(store_data),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [WW-1:0] d;
        logic [3:0]    f;
        logic [WW-1:0] st;
        int            lat;
        int            t0;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    int   cyc = 0;
    bit   finished = 0;

    logic [WW-1:0] m_d = '0;
    logic [3:0]    m_f = '0;   // {n,z,v,c}
    logic [WW-1:0] m_st = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [WW-1:0] act, input logic [WW-1:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // model the requirements and build one expected item
    task automatic model(input logic [2:0] o, input logic [WW-1:0] v, input string tag,
                         output exp_t e);
        logic [WW:0] s;
        logic [WW-1:0] r;
        logic n, c;
        e.lat = 1;
        case (o)
            3'd0: begin m_d = v; m_f = {v[15], v == 0, 1'b0, m_f[0]}; end
            3'd1: begin m_st = m_d; m_f = {m_d[15], m_d == 0, 1'b0, m_f[0]}; end
            3'd2: begin
                s = {1'b0, m_d} + {1'b0, v}; r = s[15:0];
                m_f = {r[15], r == 0, (m_d[15] == v[15]) && (r[15] != m_d[15]), s[16]};
                m_d = r;
            end
            3'd3: begin
                r = m_d - v;
                m_f = {r[15], r == 0, (m_d[15] != v[15]) && (r[15] != m_d[15]), m_d < v};
                m_d = r;
            end
            3'd4: begin
                r = WW'(m_d[15:8]) * WW'(m_d[7:0]);
                m_f[0] = r[7];
                m_d = r;
                e.lat = BW + 1;
            end
            3'd5: begin
                c = m_d[15]; r = m_d << 1; n = r[15];
                m_f = {n, r == 0, n ^ c, c}; m_d = r;
            end
            3'd6: begin
                c = m_d[0]; r = m_d >> 1;
                m_f = {1'b0, r == 0, c, c}; m_d = r;
            end
            default: ;
        endcase
        e.d = m_d; e.f = m_f; e.st = m_st; e.tag = tag;
    endtask

    task automatic issue(input logic [2:0] o, input logic [WW-1:0] v, input string tag);
        exp_t e;
        model(o, v, tag, e);
        @(negedge clk);
        e.t0 = cyc;
        q.push_back(e);
        start = 1'b1; op = o; opnd = v;
        @(negedge clk);
        start = 1'b0;
        wait (q.size() == 0);
    endtask

    // monitor: pop and compare at each done
    always @(negedge clk) begin
        if (!rst && done) begin
            if (q.size() == 0) begin
                check(1'b0, "R9", "unexpected done", d_out, '0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(d_out == e.d, e.tag, "d_out", d_out, e.d);
                check({flag_n, flag_z, flag_v, flag_c} == e.f, e.tag, "flags nzvc",
                      WW'({flag_n, flag_z, flag_v, flag_c}), WW'(e.f));
                check(store_data == e.st, e.tag, "store_data", store_data, e.st);
                check(cyc - e.t0 == e.lat, e.tag, "latency", WW'(cyc - e.t0), WW'(e.lat));
            end
        end
    end

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(d_out == 0, "R1", "reset d_out", d_out, '0);
        check({flag_n, flag_z, flag_v, flag_c} == 0, "R1", "reset flags",
              WW'({flag_n, flag_z, flag_v, flag_c}), '0);
        check(!done && !busy, "R1", "reset done/busy", WW'({done, busy}), '0);

        issue(3'd0, 16'hABCD, "R2");
        check(d_out[15:8] == 8'hAB && d_out[7:0] == 8'hCD, "R1", "byte split", d_out, 16'hABCD);
        issue(3'd0, 16'h0000, "R2");
        issue(3'd0, 16'h8001, "R2");
        issue(3'd1, 16'h0000, "R3");
        // R4 add corners
        issue(3'd0, 16'h7FFF, "R4");
        issue(3'd2, 16'h0001, "R4");
        issue(3'd0, 16'hFFFF, "R4");
        issue(3'd2, 16'h0001, "R4");
        // R5 subtract corners
        issue(3'd3, 16'h0001, "R5");
        issue(3'd0, 16'h8000, "R5");
        issue(3'd3, 16'h0001, "R5");
        // R6 multiply
        issue(3'd0, 16'hFFFF, "R6");
        issue(3'd4, 16'h0000, "R6");
        issue(3'd0, 16'h0C0B, "R6");
        issue(3'd4, 16'h0000, "R6");
        // R7 shift left
        issue(3'd0, 16'h8001, "R7");
        issue(3'd5, 16'h0000, "R7");
        issue(3'd0, 16'h4000, "R7");
        issue(3'd5, 16'h0000, "R7");
        // R8 shift right
        issue(3'd0, 16'h0001, "R8");
        issue(3'd6, 16'h0000, "R8");
        issue(3'd0, 16'h8000, "R8");
        issue(3'd6, 16'h0000, "R8");
        // R9: a load strobed during a multiply must be ignored
        issue(3'd0, 16'h1010, "R9");
        begin
            exp_t e;
            model(3'd4, 16'h0000, "R9", e);
            @(negedge clk);
            e.t0 = cyc;
            q.push_back(e);
            start = 1'b1; op = 3'd4; opnd = 16'h0000;
            @(negedge clk);
            op = 3'd0; opnd = 16'h5555;
            repeat (3) @(negedge clk);
            start = 1'b0;
            wait (q.size() == 0);
            repeat (2) @(negedge clk);
            check(d_out == 16'h0100, "R9", "pair after ignored load", d_out, 16'h0100);
        end
        // R10 reserved opcode
        issue(3'd1, 16'h0000, "R10");
        issue(3'd7, 16'h1234, "R10");
        // mixed sequence against the model
        for (int i = 0; i < 40; i++) begin
            logic [2:0] o;
            o = 3'($urandom_range(0, 7));
            issue(o, 16'($urandom), (o == 3'd4) ? "R6" : (o == 3'd2) ? "R4" :
                  (o == 3'd3) ? "R5" : (o == 3'd5) ? "R7" : (o == 3'd6) ? "R8" :
                  (o == 3'd1) ? "R3" : (o == 3'd7) ? "R10" : "R2");
        end
        repeat (3) @(negedge clk);
        finished = 1;
        summary();
    end

endmodule